// File: doc/BRIEF.md
# CSI-2 Payload Extractor for One Data Type

This block sits behind the lane-merging stage of a four-lane camera serial receiver. Each byte clock it takes one 32-bit word, which holds one byte from each lane, plus a valid flag. The flag is low between high-speed bursts. The first word of every burst carries the packet header. The block reads the data type and the 16-bit length from that word. It then passes on only the payload of long packets whose type equals a type chosen on a configuration input. The usual setting for that input is 0x2B, which selects 10-bit raw pixels.

The payload leaves the block one cycle after it arrives. Every byte keeps the lane position it had at the input. Output valid is asserted only while fewer payload bytes have been passed than the header length announced. This removes the header word and the trailing checksum word, and it drops short packets and long packets of other types. The next stage unpacks pixels from the forwarded words.

Top module: `csi_pkt_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0.
- R2: The first valid word of a burst is taken as the header and is never forwarded. `out_valid` is 0 in the cycle after it.
- R3: A forwarded payload word appears on `out_data` exactly one cycle after it was on `in_data`, with all four bytes in their original lane positions. This also holds for the final, partly filled word.
- R4: For an accepted packet with word count W, exactly ceil(W/4) consecutive payload words are forwarded. Checksum bytes that start a later word are not forwarded.
- R5: The word count is taken with header bits [15:8] as the low byte and bits [23:16] as the high byte.
- R6: The data type is header bits [5:0]. Bits [7:6] carry the virtual channel and have no effect on acceptance.
- R7: A long packet (type 0x10 or above) whose type differs from `cfg_type` produces no output. The same type is accepted when `cfg_type` is changed to it.
- R8: A short packet (type 0x00 to 0x0F) produces no output, whatever its length field holds.
- R9: When `in_valid` goes low, the burst ends. `out_valid` is 0 in the following cycle, and the next valid word is parsed as a new header.
- R10: An accepted packet with word count 0 produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_type | input | 6 | Data type to accept |
| in_valid | input | 1 | Input word valid, low between bursts |
| in_data | input | 32 | Lane-aligned word, lane 0 in bits [7:0] |
| out_valid | output | 1 | Payload word valid |
| out_data | output | 32 | Payload word, byte positions unchanged |

## Verification
The bench aims at the length boundary. A design that compares with "less or equal", or that counts in bytes against words, leaks one checksum word or cuts the last partial word. Lengths of 16, 10 and 0 separate these faults. A length of 260 exposes a swapped byte order in the count field, because the swapped value, 1025, would keep the output open for every word sent. Virtual-channel bits, short packets whose type happens to match, wrong-type long packets and a burst cut off mid-payload catch a design that decodes too many type bits, ignores the long/short split, or forgets the header state when the burst ends.

// File: rtl/csi_filt_pkg.sv
package csi_filt_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PASS = 2'd1,
        ST_SKIP = 2'd2
    } filt_st_e;

    // Lowest data type code that denotes a long packet
    localparam logic [5:0] LONG_TYPE_MIN = 6'h10;
endpackage

// File: rtl/csi_hdr_decode.sv
module csi_hdr_decode #(
    parameter int DATA_W = 32,
    parameter int DT_W   = 6,
    parameter int WC_W   = 16
) (
    input  logic [DATA_W-1:0] hdr_word,
    input  logic [DT_W-1:0]   cfg_type,
    output logic [WC_W-1:0]   hdr_wc,
    output logic              hdr_accept
);
    import csi_filt_pkg::*;

    logic [DT_W-1:0] dt;
    logic            is_long;

    always_comb begin
        dt         = hdr_word[DT_W-1:0];
        // byte 1 is the low half of the count, byte 2 the high half
        hdr_wc     = {hdr_word[23:16], hdr_word[15:8]};
        is_long    = (dt >= LONG_TYPE_MIN);
        hdr_accept = is_long && (dt == cfg_type);
    end
endmodule

// File: rtl/csi_pay_gate.sv
module csi_pay_gate #(
    parameter int LANES = 4,
    parameter int WC_W  = 16,
    parameter int CNT_W = WC_W + 1
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [WC_W-1:0]  wc_q,
    output logic             in_window,
    output logic [CNT_W-1:0] cnt_next
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(LANES);

    always_comb begin
        in_window = (cnt_q < {1'b0, wc_q});
        cnt_next  = in_window ? (cnt_q + STEP) : cnt_q;
    end
endmodule

// File: rtl/csi_pkt_filter.sv
module csi_pkt_filter #(
    parameter int LANES = 4,
    parameter int DT_W  = 6,
    parameter int WC_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DT_W-1:0]      cfg_type,
    input  logic                 in_valid,
    input  logic [LANES*8-1:0]   in_data,
    output logic                 out_valid,
    output logic [LANES*8-1:0]   out_data
);
    import csi_filt_pkg::*;

    localparam int DATA_W = LANES * 8;
    localparam int CNT_W  = WC_W + 1;

    typedef struct packed {
        filt_st_e          st;
        logic [WC_W-1:0]   wc;
        logic [CNT_W-1:0]  cnt;
        logic              ovalid;
        logic [DATA_W-1:0] odata;
    } filt_regs_t;

    filt_regs_t r_d, r_q;

    logic [WC_W-1:0]  dec_wc;
    logic             dec_accept;
    logic             gate_open;
    logic [CNT_W-1:0] gate_cnt_next;

    csi_hdr_decode #(
        .DATA_W (DATA_W),
        .DT_W   (DT_W),
        .WC_W   (WC_W)
    ) u_hdr (
        .hdr_word   (in_data),
        .cfg_type   (cfg_type),
        .hdr_wc     (dec_wc),
        .hdr_accept (dec_accept)
    );

    csi_pay_gate #(
        .LANES (LANES),
        .WC_W  (WC_W),
        .CNT_W (CNT_W)
    ) u_gate (
        .cnt_q     (r_q.cnt),
        .wc_q      (r_q.wc),
        .in_window (gate_open),
        .cnt_next  (gate_cnt_next)
    );

    always_comb begin
        r_d        = r_q;
        r_d.ovalid = 1'b0;
        if (!in_valid) begin
            r_d.st = ST_HDR;
        end else begin
            unique case (r_q.st)
                ST_HDR: begin
                    r_d.wc  = dec_wc;
                    r_d.cnt = '0;
                    r_d.st  = dec_accept ? ST_PASS : ST_SKIP;
                end
                ST_PASS: begin
                    if (gate_open) begin
                        r_d.ovalid = 1'b1;
                        r_d.odata  = in_data;
                    end
                    r_d.cnt = gate_cnt_next;
                end
                default: begin
                    r_d.st = ST_SKIP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HDR, wc: '0, cnt: '0, ovalid: 1'b0, odata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ovalid;
    assign out_data  = r_q.odata;
endmodule

// File: rtl/csi_pkt_filter_chk.sv
module csi_pkt_filter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

    AST_HDR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_valid) |=> !out_valid); // R2

    AST_DATA_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data))); // R3

    AST_GAP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R9
endmodule

bind csi_pkt_filter csi_pkt_filter_chk #(.DATA_W(LANES*8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_csi_pkt_filter.sv
module sim_csi_pkt_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_type = 6'h2B;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csi_pkt_filter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_type  (cfg_type),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one word, then look at the registered output just after the edge
    task automatic step(input logic v, input logic [31:0] d,
                        input logic exp_v, input logic [31:0] exp_d, input string req);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
        check(out_valid === exp_v, req, "out_valid", {31'b0, out_valid}, {31'b0, exp_v});
        if (exp_v)
            check(out_data === exp_d, req, "out_data", out_data, exp_d);
    endtask

    // header + ceil((wc+2)/4) words, then a two-cycle gap
    task automatic send_packet(input logic [1:0] vc, input logic [5:0] dt,
                               input logic [15:0] wc, input bit accept,
                               input logic [31:0] seed, input string req);
        int nwords;
        nwords = (int'(wc) + 2 + 3) / 4;
        step(1'b1, {8'h5A, wc[15:8], wc[7:0], vc, dt}, 1'b0, '0, req);
        for (int p = 0; p < nwords; p++) begin
            logic [31:0] w;
            bit          fwd;
            w   = seed ^ (32'h01030507 * (p + 1));
            fwd = accept && (p * 4 < int'(wc));
            step(1'b1, w, fwd, w, req);
        end
        step(1'b0, '0, 1'b0, '0, req);
        step(1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R1", "out_valid in reset", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R1", "out_valid after reset", {31'b0, out_valid}, 32'h0);
    endtask

    task automatic t_raw_aligned;   send_packet(2'd0, 6'h2B, 16'd16, 1'b1, 32'hC0DE0001, "R3 R4"); endtask
    task automatic t_raw_partial;   send_packet(2'd0, 6'h2B, 16'd10, 1'b1, 32'h1234ABCD, "R4 R3"); endtask
    task automatic t_vc_bits;       send_packet(2'd3, 6'h2B, 16'd8,  1'b1, 32'h0F0F0F0F, "R6"); endtask
    task automatic t_wc_order;      send_packet(2'd1, 6'h2B, 16'h0104, 1'b1, 32'h9E3779B9, "R5"); endtask
    task automatic t_wrong_type;    send_packet(2'd0, 6'h2A, 16'd12, 1'b0, 32'hDEADBEEF, "R7"); endtask
    task automatic t_short;         send_packet(2'd0, 6'h00, 16'd16, 1'b0, 32'h11111111, "R8"); endtask
    task automatic t_zero_len;      send_packet(2'd0, 6'h2B, 16'd0,  1'b1, 32'h22222222, "R10"); endtask

    task automatic t_retarget;
        cfg_type = 6'h2A;
        send_packet(2'd0, 6'h2A, 16'd12, 1'b1, 32'h33333333, "R7");
        send_packet(2'd0, 6'h2B, 16'd12, 1'b0, 32'h44444444, "R7");
        cfg_type = 6'h2B;
    endtask

    task automatic t_short_matching;
        cfg_type = 6'h01;
        send_packet(2'd0, 6'h01, 16'd8, 1'b0, 32'h55555555, "R8");
        cfg_type = 6'h2B;
    endtask

    task automatic t_cut_burst;
        step(1'b1, {8'h00, 8'h00, 8'd40, 2'd0, 6'h2B}, 1'b0, '0, "R9");
        step(1'b1, 32'hAAAA0001, 1'b1, 32'hAAAA0001, "R9");
        step(1'b1, 32'hAAAA0002, 1'b1, 32'hAAAA0002, "R9");
        step(1'b0, '0, 1'b0, '0, "R9");
        // new burst: header of a wrong type, nothing may pass
        step(1'b1, {8'h00, 8'h00, 8'd40, 2'd0, 6'h12}, 1'b0, '0, "R9");
        for (int i = 0; i < 4; i++)
            step(1'b1, 32'hBBBB0000 + i, 1'b0, '0, "R9");
        step(1'b0, '0, 1'b0, '0, "R9");
        // a matching header right after the gap is still honoured
        send_packet(2'd0, 6'h2B, 16'd4, 1'b1, 32'h66666666, "R9 R2");
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_raw_aligned();
        t_raw_partial();
        t_vc_bits();
        t_wc_order();
        t_wrong_type();
        t_short();
        t_short_matching();
        t_zero_len();
        t_retarget();
        t_cut_burst();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule